// File: doc/BRIEF.md
# GPIO Port Register Bank

This block is the register file behind a general-purpose I/O port of `PINS` pins (16 by default). It holds the pin data word, two interrupt mask words (A and B) and five configuration words: direction, polarity, edge select, both-edge select and input enable. Each of the data, mask-A and mask-B words has three companion addresses. A write to a companion clears, sets or toggles bits of its word. A read from a companion returns the word itself.

Software reaches the bank over a simple synchronous bus. Each request carries a byte address, a size qualifier, a write flag and write data. Exactly one cycle later the bank answers with a response code and read data. The bank drives the pin output values and output enables. It pulses a per-pin change flag whenever a write alters the level of a driven pin. It forwards the configuration words to a separate pin-sense block. It also combines that block's per-pin pending flags with the two masks into the A and B interrupt lines.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset every register reads zero, and `pin_out`, `pin_oe`, `pin_chg`, `irq_a`, `irq_b`, `resp_valid` and the four configuration outputs are all zero.
- R2: The register offsets are as follows: data 0x00, mask-A 0x10, mask-B 0x20, direction 0x30, polarity 0x34, edge 0x38, both 0x3C and input enable 0x40. A legal write to one of these offsets stores the write data, and a read issued afterwards returns it. `pin_out` shows the data word, `pin_oe` shows the direction word, and `cfg_polar`, `cfg_edge`, `cfg_both` and `cfg_inen` show their words.
- R3: A write to a group base + 0x4 (data 0x04, mask-A 0x14, mask-B 0x24) clears each bit of that word where the write data is 1 and leaves the other bits unchanged.
- R4: A write to a group base + 0x8 (0x08, 0x18, 0x28) ORs the write data into that word.
- R5: A write to a group base + 0xC (0x0C, 0x1C, 0x2C) XORs the write data into that word.
- R6: A read from any of the four addresses of a group returns the current value of that group's word.
- R7: `req_size` is encoded 0 = byte, 1 = 16-bit, 2 = 32-bit, 3 = reserved. Any size other than 1 gets `resp_code` 1 (size error), stores nothing and returns read data 0. This check wins over the unmapped check.
- R8: A 16-bit access whose `req_addr[1:0]` is not 0, or whose offset is 0x44 or above, gets `resp_code` 2 (unmapped), stores nothing and returns read data 0.
- R9: `pin_chg` is nonzero only in the cycle that follows a legal write to the data group or to direction. In that cycle it is 1 exactly for the pins whose new direction bit is 1 and whose data bit differs from its value before the write.
- R10: In each cycle, `irq_a` (`irq_b`) shows whether any pin has both its `pend_i` bit and its mask-A (mask-B) bit set. The mask value used is the one that includes any write accepted on the same edge.
- R11: `resp_valid` is 1 exactly in the cycle after each request. `resp_code` is 0 for a legal access, and the read data of every write is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address within the bank |
| req_size | input | 2 | Access size code |
| req_wdata | input | PINS | Write data |
| resp_valid | output | 1 | Response valid, one cycle after the request |
| resp_code | output | 2 | 0 ok, 1 size error, 2 unmapped |
| resp_rdata | output | PINS | Read data |
| pend_i | input | PINS | Per-pin pending flags from the sense block |
| pin_out | output | PINS | Pin output levels |
| pin_oe | output | PINS | Pin output enables |
| pin_chg | output | PINS | One-cycle flags for driven pins that changed level |
| irq_a | output | 1 | Masked interrupt line A |
| irq_b | output | 1 | Masked interrupt line B |
| cfg_polar | output | PINS | Polarity word to the sense block |
| cfg_edge | output | PINS | Edge-select word to the sense block |
| cfg_both | output | PINS | Both-edge word to the sense block |
| cfg_inen | output | PINS | Input-enable word to the sense block |

## Verification
The hardest case to reach from the ports is a companion write that flips data bits on pins that are only partly driven. A change flag must appear for the driven changed pins and stay absent for the undriven ones, in the same cycle as the response. To reach it, the bench first loads a mixed direction word. It then sweeps clear, set and toggle writes with varied patterns across every group. For each write it predicts the new word and the change mask from its own model and compares them. Separate address sweeps cover every byte address at every size code, to show that size errors win over unmapped offsets and that rejected writes leave every word untouched.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int unsigned NGRP     = 3;   // data, mask A, mask B
    localparam int unsigned NCFG     = 5;   // dir, polar, edge, both, inen
    localparam int unsigned CFG_BASE = 4 * NGRP;
    localparam int unsigned NREG     = CFG_BASE + NCFG;

    localparam int unsigned GRP_DATA  = 0;
    localparam int unsigned GRP_MASKA = 1;
    localparam int unsigned GRP_MASKB = 2;

    localparam int unsigned CFG_DIR   = 0;
    localparam int unsigned CFG_POLAR = 1;
    localparam int unsigned CFG_EDGE  = 2;
    localparam int unsigned CFG_BOTH  = 3;
    localparam int unsigned CFG_INEN  = 4;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        RSP_OK       = 2'd0,
        RSP_SIZE     = 2'd1,
        RSP_UNMAPPED = 2'd2,
        RSP_SPARE    = 2'd3
    } rsp_e;

    // Position within a group selects the modify operation.
    typedef enum logic [1:0] {
        OP_WRITE  = 2'd0,
        OP_CLEAR  = 2'd1,
        OP_SET    = 2'd2,
        OP_TOGGLE = 2'd3
    } mod_op_e;

endpackage

// File: rtl/gpio_bank_decode.sv
module gpio_bank_decode
    import gpio_bank_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        size_i,
    output rsp_e              rsp_o,
    output logic [NGRP-1:0]   grp_sel_o,
    output logic [NCFG-1:0]   cfg_sel_o,
    output mod_op_e           op_o
);

    localparam int unsigned IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic             legal;

    assign idx = addr_i[ADDR_W-1:2];

    always_comb begin
        // size check is evaluated first and therefore wins
        if (size_i != SZ_HALF) begin
            rsp_o = RSP_SIZE;
        end else if (addr_i[1:0] != 2'b00 || idx >= IDX_W'(NREG)) begin
            rsp_o = RSP_UNMAPPED;
        end else begin
            rsp_o = RSP_OK;
        end
        legal = (rsp_o == RSP_OK);
        op_o  = mod_op_e'(idx[1:0]);
        for (int g = 0; g < NGRP; g++) begin
            grp_sel_o[g] = legal && (idx >= IDX_W'(4 * g)) && (idx < IDX_W'(4 * g + 4));
        end
        for (int c = 0; c < NCFG; c++) begin
            cfg_sel_o[c] = legal && (idx == IDX_W'(CFG_BASE + c));
        end
    end

endmodule

// File: rtl/gpio_bank_modreg.sv
module gpio_bank_modreg
    import gpio_bank_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hit_i,
    input  mod_op_e      op_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] value_d_o,
    output logic [W-1:0] value_q_o
);

    logic [W-1:0] value_d, value_q;

    always_comb begin
        value_d = value_q;
        if (hit_i) begin
            unique case (op_i)
                OP_WRITE:  value_d = wdata_i;
                OP_CLEAR:  value_d = value_q & ~wdata_i;
                OP_SET:    value_d = value_q | wdata_i;
                OP_TOGGLE: value_d = value_q ^ wdata_i;
                default:   value_d = value_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) value_q <= '0;
        else        value_q <= value_d;
    end

    assign value_d_o = value_d;
    assign value_q_o = value_q;

endmodule

// File: rtl/gpio_bank_cfg.sv
module gpio_bank_cfg #(
    parameter int unsigned W = 16,
    parameter int unsigned N = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        hit_i,
    input  logic [W-1:0]        wdata_i,
    output logic [N-1:0][W-1:0] cfg_d_o,
    output logic [N-1:0][W-1:0] cfg_q_o
);

    logic [N-1:0][W-1:0] cfg_d, cfg_q;

    for (genvar c = 0; c < N; c++) begin : g_word
        always_comb begin
            cfg_d[c] = hit_i[c] ? wdata_i : cfg_q[c];
        end

        always_ff @(posedge clk) begin
            if (!rst_n) cfg_q[c] <= '0;
            else        cfg_q[c] <= cfg_d[c];
        end
    end

    assign cfg_d_o = cfg_d;
    assign cfg_q_o = cfg_q;

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_bank_pkg::*;
#(
    parameter int unsigned PINS   = 16,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [PINS-1:0]   req_wdata,
    output logic              resp_valid,
    output logic [1:0]        resp_code,
    output logic [PINS-1:0]   resp_rdata,
    input  logic [PINS-1:0]   pend_i,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_oe,
    output logic [PINS-1:0]   pin_chg,
    output logic              irq_a,
    output logic              irq_b,
    output logic [PINS-1:0]   cfg_polar,
    output logic [PINS-1:0]   cfg_edge,
    output logic [PINS-1:0]   cfg_both,
    output logic [PINS-1:0]   cfg_inen
);

    typedef struct packed {
        logic            vld;
        rsp_e            code;
        logic [PINS-1:0] rdata;
        logic [PINS-1:0] chg;
        logic            irq_a;
        logic            irq_b;
    } out_state_t;

    rsp_e                      dec_rsp;
    logic [NGRP-1:0]           grp_sel;
    logic [NCFG-1:0]           cfg_sel;
    mod_op_e                   dec_op;
    logic [NGRP-1:0]           grp_wr;
    logic [NCFG-1:0]           cfg_wr;
    logic [NGRP-1:0][PINS-1:0] grp_d, grp_q;
    logic [NCFG-1:0][PINS-1:0] cfg_d, cfg_q;
    logic [PINS-1:0]           rd_val;
    out_state_t                state_d, state_q;

    gpio_bank_decode #(.ADDR_W(ADDR_W)) i_decode (
        .addr_i    (req_addr),
        .size_i    (req_size),
        .rsp_o     (dec_rsp),
        .grp_sel_o (grp_sel),
        .cfg_sel_o (cfg_sel),
        .op_o      (dec_op)
    );

    assign grp_wr = (req_valid && req_write) ? grp_sel : '0;
    assign cfg_wr = (req_valid && req_write) ? cfg_sel : '0;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        gpio_bank_modreg #(.W(PINS)) i_word (
            .clk       (clk),
            .rst_n     (rst_n),
            .hit_i     (grp_wr[g]),
            .op_i      (dec_op),
            .wdata_i   (req_wdata),
            .value_d_o (grp_d[g]),
            .value_q_o (grp_q[g])
        );
    end

    gpio_bank_cfg #(.W(PINS), .N(NCFG)) i_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit_i   (cfg_wr),
        .wdata_i (req_wdata),
        .cfg_d_o (cfg_d),
        .cfg_q_o (cfg_q)
    );

    // Read mux: every address of a group returns the group word.
    always_comb begin
        rd_val = '0;
        for (int g = 0; g < NGRP; g++) begin
            if (grp_sel[g]) rd_val = grp_q[g];
        end
        for (int c = 0; c < NCFG; c++) begin
            if (cfg_sel[c]) rd_val = cfg_q[c];
        end
    end

    always_comb begin
        state_d       = '0;
        state_d.vld   = req_valid;
        state_d.code  = req_valid ? dec_rsp : RSP_OK;
        state_d.rdata = (req_valid && !req_write) ? rd_val : '0;
        if (grp_wr[GRP_DATA] || cfg_wr[CFG_DIR]) begin
            state_d.chg = cfg_d[CFG_DIR] & (grp_d[GRP_DATA] ^ grp_q[GRP_DATA]);
        end
        state_d.irq_a = |(pend_i & grp_d[GRP_MASKA]);
        state_d.irq_b = |(pend_i & grp_d[GRP_MASKB]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign resp_valid = state_q.vld;
    assign resp_code  = state_q.code;
    assign resp_rdata = state_q.rdata;
    assign pin_chg    = state_q.chg;
    assign irq_a      = state_q.irq_a;
    assign irq_b      = state_q.irq_b;
    assign pin_out    = grp_q[GRP_DATA];
    assign pin_oe     = cfg_q[CFG_DIR];
    assign cfg_polar  = cfg_q[CFG_POLAR];
    assign cfg_edge   = cfg_q[CFG_EDGE];
    assign cfg_both   = cfg_q[CFG_BOTH];
    assign cfg_inen   = cfg_q[CFG_INEN];

    // R9: change flags only ever name driven pins
    p_chg_driven_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_chg & ~pin_oe) == '0);

    // R9: no write in the previous cycle, no change flag
    p_chg_needs_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_write) |=> pin_chg == '0);

    // R7: wrong size reports a size error and leaves pins untouched
    p_size_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size != SZ_HALF) |=> (resp_valid && resp_code == RSP_SIZE));

    p_size_no_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_size != SZ_HALF)
        |=> ($stable(pin_out) && $stable(pin_oe) && $stable(cfg_inen)));

    // R8: unmapped write stores nothing
    p_unmapped_no_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && dec_rsp == RSP_UNMAPPED)
        |=> ($stable(pin_out) && $stable(pin_oe) && $stable(cfg_polar)
             && $stable(cfg_edge) && $stable(cfg_both) && $stable(cfg_inen)));

    // R10: nothing pending, no interrupt
    p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_i == '0) |=> (!irq_a && !irq_b));

    // R11: one response per request, in the following cycle
    p_resp_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid);

    p_resp_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !resp_valid);

endmodule

// File: tb/test_gpio_port_regs.sv
module test_gpio_port_regs;

    localparam int PINS     = 16;
    localparam int ADDR_W   = 8;
    localparam int CLK_PER  = 10;
    localparam int WD_LIMIT = 150000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [1:0]        req_size = 2'd1;
    logic [PINS-1:0]   req_wdata = '0;
    logic [PINS-1:0]   pend_i = '0;
    logic              resp_valid;
    logic [1:0]        resp_code;
    logic [PINS-1:0]   resp_rdata;
    logic [PINS-1:0]   pin_out, pin_oe, pin_chg;
    logic              irq_a, irq_b;
    logic [PINS-1:0]   cfg_polar, cfg_edge, cfg_both, cfg_inen;

    int checks = 0;
    int fails  = 0;

    // bench model: grp 0 data, 1 mask A, 2 mask B; cfg 0 dir .. 4 inen
    logic [15:0] m_grp [3];
    logic [15:0] m_cfg [5];

    always #(CLK_PER / 2) clk = ~clk;

    gpio_port_regs #(.PINS(PINS), .ADDR_W(ADDR_W)) i_gpio_port_regs (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_code(resp_code), .resp_rdata(resp_rdata),
        .pend_i(pend_i), .pin_out(pin_out), .pin_oe(pin_oe), .pin_chg(pin_chg),
        .irq_a(irq_a), .irq_b(irq_b), .cfg_polar(cfg_polar), .cfg_edge(cfg_edge),
        .cfg_both(cfg_both), .cfg_inen(cfg_inen)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_code(input logic [7:0] a, input logic [1:0] sz);
        if (sz != 2'd1) return 2'd1;
        if (a[1:0] != 2'b00 || (a >> 2) > 8'd16) return 2'd2;
        return 2'd0;
    endfunction

    function automatic logic [15:0] mdl_val(input int idx);
        if (idx < 12) return m_grp[idx / 4];
        return m_cfg[idx - 12];
    endfunction

    task automatic check_pins(input string tag);
        check({tag, " R2 pin_out"}, 32'(pin_out), 32'(m_grp[0]));
        check({tag, " R2 pin_oe"}, 32'(pin_oe), 32'(m_cfg[0]));
        check({tag, " R2 cfg_polar"}, 32'(cfg_polar), 32'(m_cfg[1]));
        check({tag, " R2 cfg_edge"}, 32'(cfg_edge), 32'(m_cfg[2]));
        check({tag, " R2 cfg_both"}, 32'(cfg_both), 32'(m_cfg[3]));
        check({tag, " R2 cfg_inen"}, 32'(cfg_inen), 32'(m_cfg[4]));
    endtask

    // One bus access with full prediction of every output.
    task automatic access(input string tag, input logic wr, input logic [7:0] a,
                          input logic [1:0] sz, input logic [15:0] wd);
        logic [1:0]  code;
        logic [15:0] old_d, exp_rd, exp_chg;
        int idx;
        code   = exp_code(a, sz);
        idx    = int'(a >> 2);
        old_d  = m_grp[0];
        exp_rd = (!wr && code == 2'd0) ? mdl_val(idx) : 16'h0;
        if (wr && code == 2'd0) begin
            if (idx < 12) begin
                case (idx % 4)
                    0: m_grp[idx / 4] = wd;
                    1: m_grp[idx / 4] = m_grp[idx / 4] & ~wd;
                    2: m_grp[idx / 4] = m_grp[idx / 4] | wd;
                    default: m_grp[idx / 4] = m_grp[idx / 4] ^ wd;
                endcase
            end else begin
                m_cfg[idx - 12] = wd;
            end
        end
        exp_chg = (wr && code == 2'd0 && (idx < 4 || idx == 12))
                  ? (m_cfg[0] & (m_grp[0] ^ old_d)) : 16'h0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " R11 valid"}, 32'(resp_valid), 32'd1);
        check({tag, " code"}, 32'(resp_code), 32'(code));
        check({tag, " rdata"}, 32'(resp_rdata), 32'(exp_rd));
        check({tag, " R9 chg"}, 32'(pin_chg), 32'(exp_chg));
        check({tag, " R10 irq_a"}, 32'(irq_a), 32'(|(pend_i & m_grp[1])));
        check({tag, " R10 irq_b"}, 32'(irq_b), 32'(|(pend_i & m_grp[2])));
        check_pins(tag);
        @(negedge clk);
        check({tag, " R11 idle"}, 32'(resp_valid), 32'd0);
        check({tag, " R9 idle chg"}, 32'(pin_chg), 32'd0);
    endtask

    task automatic read_all(input string tag);
        for (int i = 0; i < 17; i++) access(tag, 1'b0, 8'(4 * i), 2'd1, 16'h0);
    endtask

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=done", WD_LIMIT);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 3; i++) m_grp[i] = '0;
        for (int i = 0; i < 5; i++) m_cfg[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 resp_valid", 32'(resp_valid), 32'd0);
        check("R1 chg", 32'(pin_chg), 32'd0);
        check("R1 irq", 32'({irq_a, irq_b}), 32'd0);
        check_pins("R1");
        rst_n = 1'b1;
        read_all("R1 readback");

        // R2: plain words with several patterns
        for (int p = 0; p < 6; p++) begin
            logic [15:0] pat;
            pat = (p == 0) ? 16'hFFFF : (p == 1) ? 16'hA5A5 : (p == 2) ? 16'h0001
                : (p == 3) ? 16'h8000 : 16'($urandom);
            for (int i = 0; i < 17; i++) begin
                if (i >= 12 || i % 4 == 0) access("R2 write", 1'b1, 8'(4 * i), 2'd1, pat ^ 16'(i * 16'h1111));
            end
            read_all("R2 R6 readback");
        end

        // R3 R4 R5 R6 R9: companion sweeps with a partly driven port
        access("R2 dir", 1'b1, 8'h30, 2'd1, 16'h0FF0);
        for (int g = 0; g < 3; g++) begin
            for (int op = 1; op < 4; op++) begin
                for (int p = 0; p < 8; p++) begin
                    string t;
                    t = (op == 1) ? "R3 clear" : (op == 2) ? "R4 set" : "R5 toggle";
                    pend_i = 16'($urandom);
                    access(t, 1'b1, 8'(16 * g + 4 * op), 2'd1, 16'($urandom));
                    for (int k = 0; k < 4; k++) access("R6 alias", 1'b0, 8'(16 * g + 4 * k), 2'd1, 16'h0);
                end
            end
        end

        // R9: direction writes expose or hide changes; mask writes never flag
        access("R9 data", 1'b1, 8'h00, 2'd1, 16'h1234);
        access("R9 dir all", 1'b1, 8'h30, 2'd1, 16'hFFFF);
        access("R9 tgl all", 1'b1, 8'h0C, 2'd1, 16'hFFFF);
        access("R9 set same", 1'b1, 8'h08, 2'd1, m_grp[0]);
        access("R9 dir none", 1'b1, 8'h30, 2'd1, 16'h0000);
        access("R9 tgl hidden", 1'b1, 8'h0C, 2'd1, 16'h00FF);
        access("R9 maskA", 1'b1, 8'h1C, 2'd1, 16'hFFFF);

        // R10: pending pattern against masks
        for (int p = 0; p < 16; p++) begin
            pend_i = 16'(1 << p);
            access("R10 maskA", 1'b1, 8'h10, 2'd1, 16'(1 << ((p * 3) % 16)));
            access("R10 maskB", 1'b1, 8'h20, 2'd1, 16'(1 << ((p * 5) % 16)));
        end
        pend_i = '0;
        access("R10 quiet", 1'b0, 8'h00, 2'd1, 16'h0);

        // R7 R8: every address at every size, reads and writes
        for (int a = 0; a < 256; a++) begin
            for (int s = 0; s < 4; s++) begin
                string t;
                t = (s != 1) ? "R7 size" : (exp_code(8'(a), 2'(s)) == 2'd2) ? "R8 unmapped" : "R11 legal";
                access(t, 1'b0, 8'(a), 2'(s), 16'h0);
                if (exp_code(8'(a), 2'(s)) != 2'd0)
                    access(t, 1'b1, 8'(a), 2'(s), 16'(~(a * 16'h0101)));
            end
        end
        read_all("R7 R8 no store");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule